// File: doc/BRIEF.md
# Extremum-Pair Heartbeat Decision Logic

This block sits behind the feature extraction stage of a wavelet-based heartbeat detector. Each clock cycle it takes one sample's worth of features: a two-bit extremum code, a zero-crossing flag, the current wavelet coefficient and a positive and a negative threshold. A heartbeat appears in the wavelet domain as a pair of extrema of opposite sign with a zero crossing between them. The block recognises such a pair and emits a one-cycle beat marker. One sample is processed per clock.

Two cooperating state machines do the work. The pairing machine waits for an extremum that clears the threshold of its own sign, then for an optional zero crossing, then for a qualified extremum of the opposite sign. It raises a tentative-beat flag at the zero crossing, or at the closing extremum when no crossing was seen. It raises a confirm flag at the closing extremum. Each waiting state is limited by a timeout, and a confirmed pair is followed by a blanking window. The marking machine picks up the tentative flag and waits a fixed number of samples. It then looks at the confirm flag and fires the beat marker only if the flag is set. After that it clears both flags.

Top module: `mmp_beat_decider`

## Requirements
- R1: While reset is asserted and right after it is released, beat_o, cand_o and conf_o are low.
- R2: pk_code 2'b01 marks a maximum and 2'b10 a minimum. Codes 2'b00 and 2'b11 mean no extremum. A maximum qualifies only if coef > thr_hi, and a minimum only if coef < thr_lo (signed compare). Unqualified extrema, and zero crossings seen before any qualified extremum, leave cand_o and beat_o low.
- R3: A zero crossing taken while the block waits after a qualified first extremum raises cand_o on the clock edge that takes that sample.
- R4: After a zero crossing, a qualified extremum of the sign opposite to the first raises conf_o, and the pair produces exactly one beat.
- R5: A qualified opposite extremum that directly follows the first one, with no zero crossing between them, raises cand_o and conf_o on the same edge and produces one beat.
- R6: A qualified extremum of the same sign as the first one is ignored. It neither confirms nor restarts the pair.
- R7: Each waiting state (after the first extremum, and after the zero crossing) accepts its next event for TOL_SMP samples. The TOL_SMP-th sample is still accepted. With no event by then, the machine returns to idle, and a later extremum starts a new pair.
- R8: The RP_SMP samples after a confirming extremum are all ignored. The sample after them can start a new pair.
- R9: beat_o is high for exactly one cycle, DLY_SMP+1 cycles after the cycle in which cand_o rises.
- R10: cand_o and conf_o both fall DLY_SMP+2 cycles after cand_o rises, whether or not a beat was issued. Without a confirm there is no beat. A confirm that arrives while no tentative beat is pending is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock, one sample per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| pk_code | input | 2 | Extremum code: 01 maximum, 10 minimum, 00/11 none |
| zc_flag | input | 1 | Zero crossing at this sample |
| thr_hi | input | W | Signed threshold for maxima |
| thr_lo | input | W | Signed threshold for minima |
| coef | input | W | Signed wavelet coefficient of this sample |
| beat_o | output | 1 | One-cycle beat marker |
| cand_o | output | 1 | Tentative-beat flag |
| conf_o | output | 1 | Pair-confirm flag |

## Verification
The assertions check the properties that hold on every cycle:
- beat_o lasts a single cycle and is only raised while both flags are set.
- The zero-seen and opposite-seen states are entered only from the states that may precede them.
- A waiting state never outlasts TOL_SMP cycles.
- The blanking state lasts exactly RP_SMP cycles.
- The flags clear at the end of the check.

The exact cycle of each beat relative to the tentative flag, the acceptance of an event in the last sample of a window, the rejection of one sample later, and the silence under random unqualified traffic can only be shown by the bench's scenarios. The bench compares each of these with cycle numbers it computes from the requirements.

// File: rtl/mmp_pkg.sv
`timescale 1ns/1ps
package mmp_pkg;

  // extremum code carried on pk_code
  localparam logic [1:0] PK_MAX = 2'b01;
  localparam logic [1:0] PK_MIN = 2'b10;

  // pairing machine
  typedef enum logic [1:0] {
    P_NONE = 2'd0,
    P_PEAK = 2'd1,
    P_ZERO = 2'd2,
    P_OPP  = 2'd3
  } pair_st_e;

  // marking machine
  typedef enum logic [1:0] {
    M_IDLE  = 2'd0,
    M_CAND  = 2'd1,
    M_CHECK = 2'd2
  } mark_st_e;

endpackage

// File: rtl/mmp_peak_qual.sv
`timescale 1ns/1ps
module mmp_peak_qual
  import mmp_pkg::*;
#(
  parameter int W = 14
) (
  input  logic [1:0]          pk_code,
  input  logic signed [W-1:0] coef,
  input  logic signed [W-1:0] thr_hi,
  input  logic signed [W-1:0] thr_lo,
  output logic                vld_up,
  output logic                vld_dn
);

  localparam int LANES = 2;

  // true when the sample lies strictly beyond the threshold in the lane's direction
  function automatic logic beyond(input logic signed [W-1:0] c,
                                  input logic signed [W-1:0] t,
                                  input logic upward);
    beyond = upward ? (c > t) : (c < t);
  endfunction

  logic [LANES-1:0] lane_hit;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    localparam logic       UPW  = (g == 0);
    localparam logic [1:0] CODE = (g == 0) ? PK_MAX : PK_MIN;
    logic signed [W-1:0] lane_thr;
    assign lane_thr    = UPW ? thr_hi : thr_lo;
    assign lane_hit[g] = (pk_code == CODE) && beyond(coef, lane_thr, UPW);
  end

  assign vld_up = lane_hit[0];
  assign vld_dn = lane_hit[1];

endmodule

// File: rtl/mmp_pair_fsm.sv
`timescale 1ns/1ps
module mmp_pair_fsm
  import mmp_pkg::*;
#(
  parameter int TOL_SMP = 21,
  parameter int RP_SMP  = 25
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     vld_up,
  input  logic     vld_dn,
  input  logic     zc,
  output pair_st_e st,
  output logic     set_cand,
  output logic     set_conf,
  output logic     ev_timeout
);

  localparam int SPAN = (TOL_SMP > RP_SMP) ? TOL_SMP : RP_SMP;
  localparam int CW   = $clog2(SPAN + 1);
  localparam logic [CW-1:0] TOL_LAST = CW'(TOL_SMP - 1);
  localparam logic [CW-1:0] RP_LAST  = CW'(RP_SMP - 1);

  pair_st_e      nxt;
  logic [CW-1:0] dwell;
  logic          first_up, first_up_nxt;
  logic          opp_hit, any_hit, tol_end, rp_end;

  // qualified extremum whose sign differs from the one that opened the pair
  function automatic logic opposite(input logic ref_up, input logic up, input logic dn);
    opposite = ref_up ? dn : up;
  endfunction

  assign opp_hit = opposite(first_up, vld_up, vld_dn);
  assign any_hit = vld_up | vld_dn;
  assign tol_end = (dwell == TOL_LAST);
  assign rp_end  = (dwell == RP_LAST);

  always_comb begin
    nxt          = st;
    first_up_nxt = first_up;
    set_cand     = 1'b0;
    set_conf     = 1'b0;
    ev_timeout   = 1'b0;
    unique case (st)
      P_NONE: begin
        if (any_hit) begin
          nxt          = P_PEAK;
          first_up_nxt = vld_up;
        end
      end
      P_PEAK: begin
        if (opp_hit) begin
          nxt      = P_OPP;
          set_cand = 1'b1;
          set_conf = 1'b1;
        end else if (zc) begin
          nxt      = P_ZERO;
          set_cand = 1'b1;
        end else if (tol_end) begin
          nxt        = P_NONE;
          ev_timeout = 1'b1;
        end
      end
      P_ZERO: begin
        if (opp_hit) begin
          nxt      = P_OPP;
          set_conf = 1'b1;
        end else if (tol_end) begin
          nxt        = P_NONE;
          ev_timeout = 1'b1;
        end
      end
      P_OPP: begin
        if (rp_end) nxt = P_NONE;
      end
      default: nxt = P_NONE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= P_NONE;
      dwell    <= '0;
      first_up <= 1'b0;
    end else begin
      st       <= nxt;
      first_up <= first_up_nxt;
      if (nxt != st || nxt == P_NONE) dwell <= '0;
      else                            dwell <= dwell + 1'b1;
    end
  end

endmodule

// File: rtl/mmp_mark_fsm.sv
`timescale 1ns/1ps
module mmp_mark_fsm
  import mmp_pkg::*;
#(
  parameter int DLY_SMP = 21
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     set_cand,
  input  logic     set_conf,
  output mark_st_e st,
  output logic     cand_q,
  output logic     conf_q,
  output logic     beat
);

  localparam int CW = $clog2(DLY_SMP + 1);
  localparam logic [CW-1:0] DLY_LAST = CW'(DLY_SMP - 1);

  mark_st_e      nxt;
  logic [CW-1:0] cnt;
  logic          clear, conf_take;

  // a confirm only counts while a tentative beat is pending or being raised
  function automatic logic accept_conf(input logic conf_in, input logic cand_in,
                                       input logic pend, input logic clr);
    accept_conf = conf_in && (cand_in || (pend && !clr));
  endfunction

  assign clear     = (st == M_CHECK);
  assign conf_take = accept_conf(set_conf, set_cand, cand_q, clear);
  assign beat      = clear && conf_q;

  always_comb begin
    nxt = st;
    unique case (st)
      M_IDLE:  if (cand_q) nxt = M_CAND;
      M_CAND:  if (cnt == DLY_LAST) nxt = M_CHECK;
      M_CHECK: nxt = M_IDLE;
      default: nxt = M_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= M_IDLE;
      cnt    <= '0;
      cand_q <= 1'b0;
      conf_q <= 1'b0;
    end else begin
      st <= nxt;
      if (st == M_CAND && nxt == M_CAND) cnt <= cnt + 1'b1;
      else                               cnt <= '0;
      if (set_cand)   cand_q <= 1'b1;
      else if (clear) cand_q <= 1'b0;
      if (conf_take)  conf_q <= 1'b1;
      else if (clear) conf_q <= 1'b0;
    end
  end

endmodule

// File: rtl/mmp_beat_decider.sv
`timescale 1ns/1ps
module mmp_beat_decider
  import mmp_pkg::*;
#(
  parameter int W       = 14,
  parameter int TOL_SMP = 21,
  parameter int RP_SMP  = 25,
  parameter int DLY_SMP = 21
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [1:0]          pk_code,
  input  logic                zc_flag,
  input  logic signed [W-1:0] thr_hi,
  input  logic signed [W-1:0] thr_lo,
  input  logic signed [W-1:0] coef,
  output logic                beat_o,
  output logic                cand_o,
  output logic                conf_o
);

  // named internal events, watched by the bound checker
  logic     vld_up, vld_dn;
  logic     set_cand, set_conf, ev_timeout;
  pair_st_e pair_st;
  mark_st_e mark_st;

  mmp_peak_qual #(.W(W)) u_qual (
    .pk_code (pk_code),
    .coef    (coef),
    .thr_hi  (thr_hi),
    .thr_lo  (thr_lo),
    .vld_up  (vld_up),
    .vld_dn  (vld_dn)
  );

  mmp_pair_fsm #(.TOL_SMP(TOL_SMP), .RP_SMP(RP_SMP)) u_pair (
    .clk        (clk),
    .rst_n      (rst_n),
    .vld_up     (vld_up),
    .vld_dn     (vld_dn),
    .zc         (zc_flag),
    .st         (pair_st),
    .set_cand   (set_cand),
    .set_conf   (set_conf),
    .ev_timeout (ev_timeout)
  );

  mmp_mark_fsm #(.DLY_SMP(DLY_SMP)) u_mark (
    .clk      (clk),
    .rst_n    (rst_n),
    .set_cand (set_cand),
    .set_conf (set_conf),
    .st       (mark_st),
    .cand_q   (cand_o),
    .conf_q   (conf_o),
    .beat     (beat_o)
  );

endmodule

module mmp_beat_decider_chk
  import mmp_pkg::*;
#(
  parameter int TOL_SMP = 21,
  parameter int RP_SMP  = 25
) (
  input logic     clk,
  input logic     rst_n,
  input logic     beat_o,
  input logic     cand_o,
  input logic     conf_o,
  input pair_st_e pair_st,
  input mark_st_e mark_st,
  input logic     set_cand,
  input logic     set_conf,
  input logic     ev_timeout
);

  // consecutive cycles the pairing state has held its value, current cycle included
  logic [15:0] hold_q, hold_c;
  pair_st_e    st_d;

  assign hold_c = (pair_st != st_d) ? 16'd1 :
                  (hold_q == 16'hFFFF) ? hold_q : hold_q + 16'd1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_d   <= P_NONE;
      hold_q <= 16'd1;
    end else begin
      st_d   <= pair_st;
      hold_q <= hold_c;
    end
  end

  AST_RESET_QUIET: assert property (@(posedge clk) !rst_n |-> (!beat_o && !cand_o && !conf_o)); // R1
  AST_CAND_ON_SET: assert property (@(posedge clk) disable iff (!rst_n) set_cand |=> cand_o); // R3
  AST_ZERO_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    (pair_st == P_ZERO && st_d != P_ZERO) |-> (st_d == P_PEAK && cand_o)); // R3
  AST_OPP_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    (pair_st == P_OPP && st_d != P_OPP) |-> ((st_d == P_PEAK || st_d == P_ZERO) && conf_o)); // R4
  AST_DIRECT_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
    (set_cand && set_conf) |=> (cand_o && conf_o)); // R5
  AST_CONF_NEEDS_CAND: assert property (@(posedge clk) disable iff (!rst_n) conf_o |-> cand_o); // R10
  AST_WAIT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    (pair_st == P_PEAK || pair_st == P_ZERO) |-> (hold_c <= 16'(TOL_SMP))); // R7
  AST_TIMEOUT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    ev_timeout |-> (hold_c == 16'(TOL_SMP)) ##1 (pair_st == P_NONE)); // R7
  AST_BLANK_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    (pair_st != P_OPP && st_d == P_OPP) |-> (hold_q == 16'(RP_SMP))); // R8
  AST_BEAT_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) beat_o |=> !beat_o); // R9
  AST_BEAT_FLAGS: assert property (@(posedge clk) disable iff (!rst_n) beat_o |-> (cand_o && conf_o)); // R4
  AST_FLAGS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (mark_st == M_CHECK && !set_cand) |=> (!cand_o && !conf_o)); // R10

endmodule

bind mmp_beat_decider mmp_beat_decider_chk #(.TOL_SMP(TOL_SMP), .RP_SMP(RP_SMP)) u_chk (.*);

// File: tb/mmp_beat_decider_tb.sv
`timescale 1ns/1ps
module mmp_beat_decider_tb;

  localparam int W = 14, TOL = 21, RP = 25, DLY = 21;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [1:0] pk_code = 2'b00;
  logic zc_flag = 1'b0;
  logic signed [W-1:0] thr_hi, thr_lo, coef;
  logic beat_o, cand_o, conf_o;

  always #2.5 clk = ~clk;

  mmp_beat_decider #(.W(W), .TOL_SMP(TOL), .RP_SMP(RP), .DLY_SMP(DLY)) u_dut (
    .clk(clk), .rst_n(rst_n), .pk_code(pk_code), .zc_flag(zc_flag),
    .thr_hi(thr_hi), .thr_lo(thr_lo), .coef(coef),
    .beat_o(beat_o), .cand_o(cand_o), .conf_o(conf_o)
  );

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // output monitor, one time unit after each edge
  int nbeat = 0, last_beat = -1, n_rise = 0, last_rise = -1, last_fall = -1, wide = 0;
  bit beat_prev = 0, cand_prev = 0;
  always @(posedge clk) begin
    #1;
    if (beat_o) begin
      nbeat++;
      last_beat = cyc;
      if (beat_prev) wide++;
    end
    if (cand_o && !cand_prev) begin n_rise++; last_rise = cyc; end
    if (!cand_o && cand_prev) last_fall = cyc;
    beat_prev = beat_o;
    cand_prev = cand_o;
  end

  int n_chk = 0, n_fail = 0, last_e = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic bit qual(input logic [1:0] code, input int c, input int hi, input int lo);
    return (code == 2'b01 && c > hi) || (code == 2'b10 && c < lo);
  endfunction
  function automatic int beat_at(input int k);  return k + 1 + DLY; endfunction
  function automatic int clear_at(input int k); return k + 2 + DLY; endfunction

  function automatic int quiet();  return int'($urandom % 301) - 150; endfunction
  function automatic int up_amp(); return int'(thr_hi) + 1 + int'($urandom % 300); endfunction
  function automatic int dn_amp(); return int'(thr_lo) - 1 - int'($urandom % 300); endfunction

  task automatic drive(input logic [1:0] p, input bit z, input int c, output int e);
    @(negedge clk);
    pk_code = p; zc_flag = z; coef = W'(c);
    e = cyc + 1;
    last_e = e;
  endtask

  task automatic idle(input int n);
    int e;
    for (int i = 0; i < n; i++) drive(2'b00, 1'b0, quiet(), e);
  endtask

  task automatic idle_to(input int target);
    while (last_e + 1 < target) idle(1);
  endtask

  task automatic ext(input bit up, output int e);
    if (up) drive(2'b01, 1'b0, up_amp(), e);
    else    drive(2'b10, 1'b0, dn_amp(), e);
  endtask

  task automatic do_pair(input bit up_first, input bit with_zc, input int g1, input int g2,
                         output int k, output int ko);
    int e, kz;
    kz = -1;
    ext(up_first, e);
    idle(g1);
    if (with_zc) begin
      drive(2'b00, 1'b1, quiet(), kz);
      idle(g2);
    end
    ext(!up_first, ko);
    k = with_zc ? kz : ko;
  endtask

  task automatic run_pair(input bit up_first, input bit with_zc, input int g1, input int g2);
    int b, k, ko;
    string rq;
    rq = with_zc ? "R4" : "R5";
    b = nbeat;
    do_pair(up_first, with_zc, g1, g2, k, ko);
    idle(RP + DLY + 8);
    chk(nbeat == b + 1, rq, "beat count", nbeat - b, 1);
    chk(last_rise == k, with_zc ? "R3" : "R5", "cand rise cycle", last_rise, k);
    chk(last_beat == beat_at(k), "R9", "beat cycle", last_beat, beat_at(k));
    chk(last_fall == clear_at(k), "R10", "flag clear cycle", last_fall, clear_at(k));
  endtask

  initial begin
    int seed_val, b, r, e, k, ko, kz, k2;
    seed_val = $urandom(32'h5EED_0A17);
    thr_hi = 14'sd600;
    thr_lo = -14'sd600;
    coef = '0;
    repeat (4) @(negedge clk);
    chk(!beat_o && !cand_o && !conf_o, "R1", "outputs in reset", {beat_o, cand_o, conf_o}, 0);
    rst_n = 1'b1;
    idle(3);
    chk(!beat_o && !cand_o && !conf_o, "R1", "outputs after reset", {beat_o, cand_o, conf_o}, 0);

    // R2: random unqualified traffic, including exact threshold values
    b = nbeat; r = n_rise;
    for (int i = 0; i < 400; i++) begin
      logic [1:0] code;
      int c;
      code = 2'($urandom % 4);
      if (code == 2'b11) c = int'($urandom % 8001) - 4000;
      else c = int'(thr_lo) + int'($urandom % 1201);
      if (i % 50 == 0) begin code = 2'b01; c = int'(thr_hi); end
      if (i % 50 == 25) begin code = 2'b10; c = int'(thr_lo); end
      if (qual(code, c, int'(thr_hi), int'(thr_lo))) c = 0;
      drive(code, 1'($urandom % 2), c, e);
    end
    idle(TOL + 5);
    chk(n_rise == r, "R2", "cand rises on unqualified traffic", n_rise - r, 0);
    chk(nbeat == b, "R2", "beats on unqualified traffic", nbeat - b, 0);

    // directed pairs
    run_pair(1'b1, 1'b1, 0, 0);
    run_pair(1'b1, 1'b1, TOL - 1, TOL - 1);  // R7 last accepted sample
    run_pair(1'b0, 1'b0, TOL - 1, 0);        // R5 direct pair

    // R7: first extremum times out, later opposite one opens a new pair
    b = nbeat; r = n_rise;
    ext(1'b1, e);
    idle(TOL);
    ext(1'b0, e);
    idle(TOL + 5);
    chk(n_rise == r, "R7", "cand rises after timeout", n_rise - r, 0);
    chk(nbeat == b, "R7", "beats after timeout", nbeat - b, 0);

    // R7/R10: zero-seen state times out, tentative beat dropped
    b = nbeat;
    ext(1'b1, e);
    drive(2'b00, 1'b1, quiet(), kz);
    idle(TOL);
    ext(1'b0, e);
    idle(RP + DLY + 8);
    chk(nbeat == b, "R10", "beat without confirm", nbeat - b, 0);
    chk(last_rise == kz, "R3", "cand rise at zero crossing", last_rise, kz);
    chk(last_fall == clear_at(kz), "R10", "unconfirmed clear cycle", last_fall, clear_at(kz));

    // R6: same-sign extremum after the zero crossing does not confirm
    b = nbeat;
    ext(1'b1, e);
    drive(2'b00, 1'b1, quiet(), kz);
    ext(1'b1, e);
    idle(RP + DLY + 8);
    chk(nbeat == b, "R6", "same-sign after zero", nbeat - b, 0);
    chk(last_fall == clear_at(kz), "R6", "same-sign clear cycle", last_fall, clear_at(kz));

    // R6: same-sign extremum while waiting for the pair, then opposite closes it
    b = nbeat;
    ext(1'b1, e);
    ext(1'b1, e);
    ext(1'b0, k);
    idle(RP + DLY + 8);
    chk(nbeat == b + 1, "R6", "pair after same-sign repeat", nbeat - b, 1);
    chk(last_beat == beat_at(k), "R6", "beat cycle after repeat", last_beat, beat_at(k));

    // R8: blanking window
    b = nbeat;
    do_pair(1'b1, 1'b1, 2, 2, k, ko);
    idle(3);
    ext(1'b1, e);
    drive(2'b00, 1'b1, quiet(), e);
    ext(1'b0, e);
    idle_to(ko + RP);
    chk(nbeat == b + 1, "R8", "beats inside window", nbeat - b, 1);
    chk(last_beat == beat_at(k), "R8", "first beat cycle", last_beat, beat_at(k));
    ext(1'b1, e);                 // last blanked sample
    ext(1'b0, e);                 // first sample after the window opens a pair
    drive(2'b00, 1'b1, quiet(), k2);
    ext(1'b1, e);
    idle(RP + DLY + 8);
    chk(nbeat == b + 2, "R8", "beats after window", nbeat - b, 2);
    chk(last_beat == beat_at(k2), "R8", "second beat cycle", last_beat, beat_at(k2));

    // constrained random pairs with varying thresholds
    for (int i = 0; i < 16; i++) begin
      thr_hi = W'(200 + int'($urandom % 1500));
      thr_lo = W'(-(200 + int'($urandom % 1500)));
      idle(2);
      run_pair(1'($urandom % 2), 1'($urandom % 2), int'($urandom % TOL), int'($urandom % TOL));
    end

    chk(wide == 0, "R9", "beats longer than one cycle", wide, 0);
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(100000 * 5);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL R9 watchdog expired: actual %0d expected %0d", cyc, 0);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

endmodule